// File: doc/BRIEF.md
# Sine Delta-Sigma Test Bitstream Generator

This block turns a loadable table of sine samples into a 1-bit delta-sigma stream and a matching bit clock for an external test DAC. A host first writes one period of the waveform into the table. The number of points it writes, together with the interpolation factor, sets the frequency of the test tone. While running, the block walks the table one bit period at a time. It scales each table point by a programmable gain and interpolates linearly between neighbouring points. The resulting value drives a second-order modulator, whose one-bit output is the stream.

The bit clock can be shifted against the data in eighth-of-a-bit steps. This lets the DAC sample the data away from its transitions. A sync input can restart the waveform at the first table point, so the tone can be aligned with an external event. A loopback selector sends the stream, in place of the external modulator bits, to every lane of the modulator data path. When generation is stopped, the stream carries a plain alternating idle pattern.

Top module: `sine_bitstream_gen`

## Requirements
- R1: During reset and directly after it, `bs_data` and `bs_clk` are 0, the table position is entry 0, and both modulator integrators are cleared.
- R2: A bit boundary falls on every eighth clock. At each bit boundary with `run` low, `bs_data` inverts, giving a 1,0,1,0 pattern. The integrators and the table position are cleared at the same time.
- R3: With t counting clocks since the last bit boundary (0 on the clock at which the new bit appears) and p the value of `phase`, `bs_clk` is 1 exactly when (t − p) mod 8 is 4 or more. The result is a 50 % clock delayed by p eighths of a bit.
- R4: `bs_data` changes only at bit boundaries.
- R5: A table word x (24-bit two's complement) is scaled as s = (x·g) >>> 23, where g is `gain` read as unsigned with 0x800000 = 1.0. The result saturates to the range −2^23 … 2^23−1.
- R6: Let K = `interp`+1 and let f be the bit's sub-step (0 … K−1). The modulator input is u = s(a)·(K−f) + s(b)·f, where a is the current table point and b the next. After the last table point (`tbl_last`) the next point is entry 0. After K bits the position advances one point, wrapping from `tbl_last` to 0.
- R7: At each running bit boundary, the bit v is 1 when integrator x2 is ≥ 0. With F = K·2^23 and feedback e = +F for v = 1 and −F for v = 0, the updates are x1 ← x1 + u − e and then x2 ← x2 + x1(new) − e. The bit v appears on `bs_data`.
- R8: For a constant scaled input c (as a fraction of full scale), the density of ones over a long run is (1+c)/2.
- R9: When `restart_en` is 1, a `sync` pulse makes the next bit use table entry 0 with sub-step 0, and the integrators are kept. When `restart_en` is 0, `sync` has no effect.
- R10: With `loop_en` high, every bit of `mod_data_out` equals `bs_data`. With it low, `mod_data_out` equals `mod_data_in`.
- R11: A write with `tbl_we` high stores `tbl_wdata` at `tbl_addr` on the clock edge. A bit boundary on that same edge still uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Enables tone generation |
| loop_en | input | 1 | Routes the stream onto the modulator data path |
| sync | input | 1 | Synchronisation event pulse |
| restart_en | input | 1 | Lets `sync` restart the waveform at entry 0 |
| interp | input | 8 | Interpolation factor minus one |
| phase | input | 3 | Bit clock delay in eighths of a bit |
| gain | input | 24 | Unsigned gain, 0x800000 = 1.0 |
| tbl_last | input | 10 | Index of the last table point in use |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 10 | Table write address |
| tbl_wdata | input | 24 | Table write data, two's complement |
| mod_data_in | input | 4 | External modulator bits, one per lane |
| mod_data_out | output | 4 | Modulator bits after the loopback selector |
| bs_data | output | 1 | Delta-sigma output stream |
| bs_clk | output | 1 | Bit clock for the stream |

## Verification
The integrator headroom check assumes that the scaled samples stay within about 0.6 of full scale. A second-order loop driven harder can let its integrators grow without bound. The bench therefore keeps the product of table amplitude and gain below that level. The only exception is a short saturated-input run, which still sits at the exact full-scale rail. The pointer-wrap and restart checks assume that `interp` and `tbl_last` are changed only while `run` is low, and the stimulus reconfigures them only in idle gaps.

// File: rtl/sbg_pkg.sv
// Shared sizing constants for the sine bitstream generator.
// Assumes: all modules take their default parameters from here.
package sbg_pkg;
    localparam int SBG_DATA_W   = 24;   // table sample width
    localparam int SBG_GAIN_W   = 24;   // gain width, 1.0 at 2^(GAIN_W-1)
    localparam int SBG_DEPTH    = 1024; // table points
    localparam int SBG_INTERP_W = 8;    // interpolation field width
    localparam int SBG_PHASE_W  = 3;    // clocks per bit = 2^PHASE_W
    localparam int SBG_LANES    = 4;    // modulator data lanes
    localparam int SBG_ACC_W    = 48;   // modulator integrator width
endpackage

// File: rtl/sbg_bitclk.sv
// Bit timing: a free-running clock divider that marks the last clock of
// each bit period and builds the phase-shifted bit clock.
// Assumes: phase may change at any time; the clock follows it next cycle.
module sbg_bitclk #(
    parameter int PHASE_W = sbg_pkg::SBG_PHASE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] phase,
    output logic               bit_tick,
    output logic               bs_clk
);
    logic [PHASE_W-1:0] tick;
    logic [PHASE_W-1:0] tick_nx;
    logic [PHASE_W-1:0] shifted;

    // Next count and its offset by the requested phase.
    always_comb begin
        tick_nx  = tick + PHASE_W'(1);
        shifted  = tick_nx - phase;
        bit_tick = &tick;
    end

    // Divider count and registered bit clock (upper half of shifted count).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick   <= '0;
            bs_clk <= 1'b0;
        end else begin
            tick   <= tick_nx;
            bs_clk <= shifted[PHASE_W-1];
        end
    end
endmodule

// File: rtl/sbg_table.sv
// Waveform store with one write port and two combinational read ports,
// each followed by a gain multiply with saturation.
// Assumes: contents are written before generation starts; unwritten
// entries hold whatever the storage powers up with.
module sbg_table #(
    parameter int DATA_W = sbg_pkg::SBG_DATA_W,
    parameter int GAIN_W = sbg_pkg::SBG_GAIN_W,
    parameter int DEPTH  = sbg_pkg::SBG_DEPTH,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PORTS  = 2
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [GAIN_W-1:0]           gain,
    input  logic [PORTS-1:0][ADDR_W-1:0] rd_addr,
    output logic [PORTS-1:0][DATA_W-1:0] rd_scaled
);
    localparam int PW = DATA_W + GAIN_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];

    // Table write port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar gp = 0; gp < PORTS; gp++) begin : g_port
        logic signed [PW-1:0] prod;
        logic signed [PW-1:0] shr;

        // Read, multiply by unsigned gain, rescale and clamp to DATA_W.
        always_comb begin
            prod = PW'($signed(mem[rd_addr[gp]])) * $signed({1'b0, gain});
            shr  = prod >>> (GAIN_W - 1);
            if ((shr[PW-1:DATA_W-1] == '0) || (shr[PW-1:DATA_W-1] == '1)) begin
                rd_scaled[gp] = shr[DATA_W-1:0];
            end else if (shr[PW-1]) begin
                rd_scaled[gp] = {1'b1, {(DATA_W-1){1'b0}}};
            end else begin
                rd_scaled[gp] = {1'b0, {(DATA_W-1){1'b1}}};
            end
        end
    end
endmodule

// File: rtl/sbg_seq.sv
// Waveform sequencer: table position, interpolation sub-step, sync
// restart, and the linear interpolation that forms the modulator input.
// Assumes: interp and last are changed only while run is low.
module sbg_seq #(
    parameter int DATA_W   = sbg_pkg::SBG_DATA_W,
    parameter int DEPTH    = sbg_pkg::SBG_DEPTH,
    parameter int INTERP_W = sbg_pkg::SBG_INTERP_W,
    localparam int ADDR_W  = $clog2(DEPTH),
    localparam int WW      = INTERP_W + 2,
    localparam int UW      = DATA_W + INTERP_W + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_tick,
    input  logic                    run,
    input  logic                    sync,
    input  logic                    restart_en,
    input  logic [INTERP_W-1:0]     interp,
    input  logic [ADDR_W-1:0]       last,
    input  logic [1:0][DATA_W-1:0]  scaled,
    output logic [1:0][ADDR_W-1:0]  rd_addr,
    output logic signed [UW-1:0]    mod_in
);
    logic [ADDR_W-1:0]   ptr;
    logic [INTERP_W-1:0] frac;
    logic                pend;
    logic                restart_hit;
    logic signed [WW-1:0] w_cur;
    logic signed [WW-1:0] w_nxt;

    // Read addresses for the current point and its wrapped successor.
    always_comb begin
        rd_addr[0] = ptr;
        rd_addr[1] = (ptr >= last) ? '0 : ptr + ADDR_W'(1);
    end

    // Linear interpolation weights and the weighted sum.
    always_comb begin
        w_cur  = $signed({2'b00, interp}) - $signed({2'b00, frac}) + WW'(1);
        w_nxt  = $signed({2'b00, frac});
        mod_in = UW'($signed(scaled[0])) * UW'(w_cur)
               + UW'($signed(scaled[1])) * UW'(w_nxt);
    end

    assign restart_hit = pend | (sync & restart_en);

    // Position update at each bit boundary; sync restart is remembered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            frac <= '0;
            pend <= 1'b0;
        end else if (bit_tick) begin
            pend <= 1'b0;
            if (!run || restart_hit) begin
                ptr  <= '0;
                frac <= '0;
            end else if (frac >= interp) begin
                frac <= '0;
                ptr  <= (ptr >= last) ? '0 : ptr + ADDR_W'(1);
            end else begin
                frac <= frac + INTERP_W'(1);
            end
        end else if (sync && restart_en) begin
            pend <= 1'b1;
        end
    end

    // R9: a restart lands the next bit on entry 0, sub-step 0.
    a_r9_restart_to_start: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && run && restart_hit) |=> (ptr == '0 && frac == '0));

    // R6: the last sub-step of the last point wraps to entry 0.
    a_r6_table_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && run && !restart_hit && frac >= interp && ptr >= last)
        |=> (ptr == '0 && frac == '0));
endmodule

// File: rtl/sbg_mod2.sv
// Second-order error-feedback delta-sigma loop with a sign quantiser,
// plus the alternating idle pattern while generation is stopped.
// Assumes: |mod_in| stays well below full scale K*2^(DATA_W-1).
module sbg_mod2 #(
    parameter int DATA_W   = sbg_pkg::SBG_DATA_W,
    parameter int INTERP_W = sbg_pkg::SBG_INTERP_W,
    parameter int ACC_W    = sbg_pkg::SBG_ACC_W,
    localparam int UW      = DATA_W + INTERP_W + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 run,
    input  logic [INTERP_W-1:0]  interp,
    input  logic signed [UW-1:0] mod_in,
    output logic                 bs_data
);
    logic signed [ACC_W-1:0] x1, x2;
    logic signed [ACC_W-1:0] full, fb, x1_nx, x2_nx;

    // Full scale, feedback by sign of x2, and next integrator values.
    always_comb begin
        full  = (ACC_W'(interp) + ACC_W'(1)) << (DATA_W - 1);
        fb    = x2[ACC_W-1] ? -full : full;
        x1_nx = x1 + ACC_W'(mod_in) - fb;
        x2_nx = x2 + x1_nx - fb;
    end

    // Loop update on running bits; idle toggling with cleared state otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x1      <= '0;
            x2      <= '0;
            bs_data <= 1'b0;
        end else if (bit_tick) begin
            if (run) begin
                x1      <= x1_nx;
                x2      <= x2_nx;
                bs_data <= ~x2[ACC_W-1];
            end else begin
                x1      <= '0;
                x2      <= '0;
                bs_data <= ~bs_data;
            end
        end
    end

    // R2: every idle bit boundary inverts the output.
    a_r2_idle_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !run) |=> (bs_data != $past(bs_data)));

    // R7: both integrators keep four guard bits of headroom.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ((x2[ACC_W-1 -: 4] == '0) || (x2[ACC_W-1 -: 4] == '1)) &&
        ((x1[ACC_W-1 -: 4] == '0) || (x1[ACC_W-1 -: 4] == '1)));
endmodule

// File: rtl/sine_bitstream_gen.sv
// Top level: ties bit timing, waveform table, sequencer and modulator
// together and places the loopback selector on the modulator data lanes.
// Assumes: one clock domain; the DAC samples bs_data on rising bs_clk.
module sine_bitstream_gen #(
    parameter int DATA_W   = sbg_pkg::SBG_DATA_W,
    parameter int GAIN_W   = sbg_pkg::SBG_GAIN_W,
    parameter int DEPTH    = sbg_pkg::SBG_DEPTH,
    parameter int INTERP_W = sbg_pkg::SBG_INTERP_W,
    parameter int PHASE_W  = sbg_pkg::SBG_PHASE_W,
    parameter int LANES    = sbg_pkg::SBG_LANES,
    parameter int ACC_W    = sbg_pkg::SBG_ACC_W,
    localparam int ADDR_W  = $clog2(DEPTH),
    localparam int UW      = DATA_W + INTERP_W + 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                loop_en,
    input  logic                sync,
    input  logic                restart_en,
    input  logic [INTERP_W-1:0] interp,
    input  logic [PHASE_W-1:0]  phase,
    input  logic [GAIN_W-1:0]   gain,
    input  logic [ADDR_W-1:0]   tbl_last,
    input  logic                tbl_we,
    input  logic [ADDR_W-1:0]   tbl_addr,
    input  logic [DATA_W-1:0]   tbl_wdata,
    input  logic [LANES-1:0]    mod_data_in,
    output logic [LANES-1:0]    mod_data_out,
    output logic                bs_data,
    output logic                bs_clk
);
    logic                    bit_tick;
    logic [1:0][ADDR_W-1:0]  rd_addr;
    logic [1:0][DATA_W-1:0]  scaled;
    logic signed [UW-1:0]    mod_in;

    sbg_bitclk #(.PHASE_W(PHASE_W)) u_bitclk (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .bit_tick(bit_tick), .bs_clk(bs_clk)
    );

    sbg_table #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .DEPTH(DEPTH)) u_table (
        .clk(clk), .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_data(tbl_wdata),
        .gain(gain), .rd_addr(rd_addr), .rd_scaled(scaled)
    );

    sbg_seq #(.DATA_W(DATA_W), .DEPTH(DEPTH), .INTERP_W(INTERP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .run(run),
        .sync(sync), .restart_en(restart_en), .interp(interp),
        .last(tbl_last), .scaled(scaled), .rd_addr(rd_addr), .mod_in(mod_in)
    );

    sbg_mod2 #(.DATA_W(DATA_W), .INTERP_W(INTERP_W), .ACC_W(ACC_W)) u_mod2 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .run(run),
        .interp(interp), .mod_in(mod_in), .bs_data(bs_data)
    );

    // Loopback selector, one lane at a time.
    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
        assign mod_data_out[gl] = loop_en ? bs_data : mod_data_in[gl];
    end

    // R4: the stream moves only on the clock after a bit boundary.
    a_r4_data_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bs_data) |-> $past(bit_tick));
endmodule

// File: tb/sine_bitstream_gen_test.sv
module sine_bitstream_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0, loop_en = 1'b0, sync = 1'b0, restart_en = 1'b0;
    logic [7:0]  interp = '0;
    logic [2:0]  phase = '0;
    logic [23:0] gain = 24'h800000;
    logic [9:0]  tbl_last = '0;
    logic        tbl_we = 1'b0;
    logic [9:0]  tbl_addr = '0;
    logic [23:0] tbl_wdata = '0;
    logic [3:0]  mod_data_in = '0;
    logic [3:0]  mod_data_out;
    logic        bs_data, bs_clk;

    int checks = 0, bad = 0;
    bit cmp_en = 1'b0, done = 1'b0;
    string dtag = "R1";

    // reference model state
    longint mtab [0:1023];
    int     m_tick = 0, m_ptr = 0, m_frac = 0;
    bit     m_data = 0, m_clk = 0, m_pend = 0;
    longint x1 = 0, x2 = 0;

    sine_bitstream_gen uut (
        .clk(clk), .rst_n(rst_n), .run(run), .loop_en(loop_en), .sync(sync),
        .restart_en(restart_en), .interp(interp), .phase(phase), .gain(gain),
        .tbl_last(tbl_last), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .mod_data_in(mod_data_in),
        .mod_data_out(mod_data_out), .bs_data(bs_data), .bs_clk(bs_clk)
    );

    always #5 clk = ~clk;

    function automatic longint scl(input longint raw);
        longint p;
        p = (raw * longint'(gain)) >>> 23;
        if (p > 64'sd8388607) p = 64'sd8388607;
        if (p < -64'sd8388608) p = -64'sd8388608;
        return p;
    endfunction

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tick = 0; m_ptr = 0; m_frac = 0; m_data = 0; m_clk = 0;
            m_pend = 0; x1 = 0; x2 = 0;
        end else begin
            if (m_tick == 7) begin
                if (run) begin
                    longint k, fs, a, b, u, fb;
                    int nx;
                    bit v;
                    k  = longint'(interp) + 1;
                    fs = k * 64'sd8388608;
                    nx = (m_ptr >= int'(tbl_last)) ? 0 : m_ptr + 1;
                    a  = scl(mtab[m_ptr]);
                    b  = scl(mtab[nx]);
                    u  = a * (k - m_frac) + b * m_frac;
                    v  = (x2 >= 0);
                    fb = v ? fs : -fs;
                    x1 = x1 + u - fb;
                    x2 = x2 + x1 - fb;
                    m_data = v;
                    if (m_pend || (sync && restart_en)) begin
                        m_ptr = 0; m_frac = 0;
                    end else if (m_frac >= int'(interp)) begin
                        m_frac = 0;
                        m_ptr  = (m_ptr >= int'(tbl_last)) ? 0 : m_ptr + 1;
                    end else begin
                        m_frac = m_frac + 1;
                    end
                end else begin
                    x1 = 0; x2 = 0; m_data = !m_data; m_ptr = 0; m_frac = 0;
                end
                m_pend = 0;
            end else if (sync && restart_en) begin
                m_pend = 1;
            end
            m_clk  = (((m_tick + 1 - int'(phase)) & 7) >= 4);
            m_tick = (m_tick + 1) & 7;
            if (tbl_we) mtab[tbl_addr] = longint'($signed(tbl_wdata));
        end
    end

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            logic [3:0] em;
            em = loop_en ? {4{m_data}} : mod_data_in;
            checks += 3;
            if (bs_data !== m_data) begin
                bad++;
                $display("FAIL R4 %s bs_data got %0b exp %0b at %0t", dtag, bs_data, m_data, $time);
            end
            if (bs_clk !== m_clk) begin
                bad++;
                $display("FAIL R3 bs_clk got %0b exp %0b at %0t", bs_clk, m_clk, $time);
            end
            if (mod_data_out !== em) begin
                bad++;
                $display("FAIL R10 mod_data_out got %h exp %h at %0t", mod_data_out, em, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input int addr, input int val);
        @(posedge clk); #2;
        tbl_we = 1'b1; tbl_addr = addr[9:0]; tbl_wdata = val[23:0];
        @(posedge clk); #2;
        tbl_we = 1'b0;
    endtask

    task automatic pulse_sync;
        @(posedge clk); #2; sync = 1'b1;
        @(posedge clk); #2; sync = 1'b0;
    endtask

    task automatic density(input int nbits, input int lo, input int hi, input string tag);
        int ones = 0;
        for (int i = 0; i < nbits; i++) begin
            repeat (8) @(negedge clk);
            ones += bs_data;
        end
        checks++;
        if (ones < lo || ones > hi) begin
            bad++;
            $display("FAIL %s ones density got %0d exp %0d..%0d", tag, ones, lo, hi);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic a0, a1;
        for (int i = 0; i < 1024; i++) mtab[i] = 0;
        // R1: reset state
        repeat (3) @(negedge clk);
        checks += 2;
        if (bs_data !== 1'b0) begin bad++; $display("FAIL R1 bs_data got %0b exp 0", bs_data); end
        if (bs_clk !== 1'b0)  begin bad++; $display("FAIL R1 bs_clk got %0b exp 0", bs_clk); end
        step(1); rst_n = 1'b1;
        @(negedge clk); cmp_en = 1'b1;

        // R2: idle alternation
        dtag = "R2";
        step(40);
        @(negedge clk); a0 = bs_data;
        repeat (8) @(negedge clk); a1 = bs_data;
        checks++;
        if (a0 == a1) begin bad++; $display("FAIL R2 idle got %0b then %0b exp toggle", a0, a1); end

        // load a 16-point sine, interp 4, unity gain (R5, R6, R7, R11)
        dtag = "R6";
        for (int i = 0; i < 16; i++)
            wr(i, $rtoi(0.4 * 8388608.0 * $sin(6.283185307179586 * i / 16.0)));
        tbl_last = 10'd15; interp = 8'd3; run = 1'b1;
        step(1200);
        // R3: other clock phases
        dtag = "R3"; phase = 3'd3; step(200); phase = 3'd6; step(200); phase = 3'd0;
        // R5: gain 1.5
        dtag = "R5"; gain = 24'hC00000; step(800);
        // R5: saturation at the rail
        run = 1'b0; step(16);
        for (int i = 0; i < 16; i++) wr(i, 24'h7FFFFF);
        gain = 24'hFFFFFF; interp = 8'd0; run = 1'b1; step(400);
        // R6: short table, no interpolation
        run = 1'b0; step(16); dtag = "R6";
        for (int i = 0; i < 5; i++) wr(i, (i - 2) * 24'sh0F0000);
        gain = 24'h800000; tbl_last = 10'd4; run = 1'b1; step(500);
        // R9: sync restart on and off
        run = 1'b0; step(16); interp = 8'd2; run = 1'b1; dtag = "R9";
        restart_en = 1'b1; step(37); pulse_sync(); step(101); pulse_sync(); step(60);
        restart_en = 1'b0; step(29); pulse_sync(); step(80);
        // R10: loopback against external lanes
        loop_en = 1'b1; mod_data_in = 4'hA; step(120);
        loop_en = 1'b0; mod_data_in = 4'h5; step(40); mod_data_in = 4'h3; step(40);
        // R11: table rewrite while running
        dtag = "R11";
        for (int i = 0; i < 5; i++) begin wr(i, (2 - i) * 24'sh0C0000); step(13); end
        step(200);
        // R8: ones density tracks scaled DC level
        run = 1'b0; step(16); dtag = "R8";
        for (int i = 0; i < 8; i++) wr(i, 24'h200000);
        tbl_last = 10'd7; interp = 8'd0; gain = 24'h800000; run = 1'b1;
        step(512); density(1024, 632, 648, "R8 c=0.25");
        gain = 24'h400000; step(512); density(1024, 568, 584, "R8 c=0.125");
        run = 1'b0; step(16);
        for (int i = 0; i < 8; i++) wr(i, -24'sh300000);
        gain = 24'h800000; run = 1'b1;
        step(512); density(1024, 312, 328, "R8 c=-0.375");

        cmp_en = 1'b0; done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule